// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block runs the command and result phases of a PC-style floppy disk controller behind an 8-bit register port with a 3-bit address. The host writes an opcode byte and then its parameter bytes to the data register. The sequencer collects the bytes, decodes the operation and gives a one-cycle start pulse to an external execution engine. The engine does the sector data movement and the media timing. When the engine reports completion, the sequencer latches seven result bytes, raises an interrupt and returns the bytes one per read of the data register. An opcode it does not recognise goes straight to a one-byte result phase and never reaches the engine. The block also holds the digital output register, whose run bit holds the sequencer in soft reset, and it builds a main status register from its state.

There are four states. `ST_IDLE` waits for an opcode. `ST_PARAM` collects parameter bytes. `ST_EXEC` waits for the engine. `ST_RESULT` returns result bytes. The transitions are:
- idle→param on a recognised opcode.
- idle→result on an unrecognised opcode.
- param→exec on the last parameter byte, which also fires the start pulse.
- exec→result on `exec_done`.
- result→idle on the read of the last result byte.
- any state→idle whenever the effective run bit is 0, including the cycle in which a register write clears it.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After `rst_n` is released, the digital output register reads 0x00, the main status register reads 0x00, and `irq` and `exec_start` are 0.
- R2: A write at offset 2 loads the digital output register, and a read at offset 2 returns it. The fields are:
  - bits 1:0: `drive_sel`.
  - bit 2: run (1 = out of soft reset).
  - bit 3: `dma_gate`.
  - bits 7:4: `motor_en[3:0]`.
  For example, 0x1C gives motor 0 on, the DMA gate on, run = 1 and drive 0.
- R3: While run is 0, writes to the data register are ignored and the status register at offset 4 reads 0x00. Clearing run abandons any command in progress and clears `irq`, so that after run is set again the status register reads 0x80.
- R4: The status register at offset 4 reads as follows:
  - Bit 7 is request-for-master. Bit 6 is direction (1 = controller to host). Bit 4 is busy.
  - The resulting values are 0x80 in idle, 0x90 while collecting parameters, 0x10 while executing and 0xD0 in the result phase.
- R5: The opcode is written to offset 5. Its low 5 bits select the operation: 0x06 is read data, 0x05 is write data and 0x0D is format track. Its bits 7, 6 and 5 appear on `exec_flags[2]`, `exec_flags[1]` and `exec_flags[0]`.
- R6: Read data and write data collect exactly 8 parameter bytes. The order is drive/head, cylinder, head, sector, size code, end-of-track, gap, data length. After the clock edge that takes the 8th byte, `exec_start` is 1 for exactly one cycle. At that point `exec_params[8i+7:8i]` holds the i-th byte, and `exec_op` is 0 for read data and 1 for write data.
- R7: Format track collects exactly 5 parameter bytes: drive/head, size code, sectors per track, gap, filler. It then pulses `exec_start` with `exec_op` = 2. `fmt_id_bytes` equals 4 × sectors per track, which is the count of sector ID bytes the engine will take.
- R8: `exec_done` in the execution state latches `exec_result` and sets `irq` on the next edge. The data register then returns seven bytes, starting with `exec_result[7:0]` and moving upward one byte per read. After the seventh read the sequencer is idle.
- R9: The first result-byte read clears `irq`.
- R10: An unrecognised opcode produces no `exec_start` and leaves `irq` at 0. The next data read returns 0x80 and returns the sequencer to idle.
- R11: Data-register writes during execution or the result phase are ignored, and `exec_done` outside the execution state is ignored. A data read outside the result phase returns 0x00.
- R12: If a write that clears run lands in the same cycle as `exec_done`, the clear wins: `irq` stays 0 and no result phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Completion interrupt |
| drive_sel | output | 2 | Selected drive |
| dma_gate | output | 1 | DMA/interrupt gate bit |
| motor_en | output | 4 | Motor enables, drives 0 to 3 |
| exec_start | output | 1 | One-cycle start to the engine |
| exec_op | output | 2 | 0 read, 1 write, 2 format |
| exec_flags | output | 3 | Multi-track, MFM, skip |
| exec_params | output | 64 | Parameter bytes, byte i at bits 8i+7:8i |
| fmt_id_bytes | output | 10 | Sector ID byte count for format |
| exec_done | input | 1 | Engine completion |
| exec_result | input | 56 | Seven result bytes, first at bits 7:0 |

## Verification
Two events can arrive on the same clock edge: the engine's completion and a register write that clears the run bit. The bench raises `exec_done` and a write of 0x18 to offset 2 in the same cycle while the sequencer is executing. On the next cycle it expects `irq` at 0 and a status register of 0x00. After run is restored it expects 0x80 and no pending result bytes. A stray `exec_done` while idle, and data writes during execution, are also driven. The bench then judges that `irq`, the status register and the held parameters do not change.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PARAM  = 2'd1,
        ST_EXEC   = 2'd2,
        ST_RESULT = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OPK_READ   = 2'd0,
        OPK_WRITE  = 2'd1,
        OPK_FORMAT = 2'd2,
        OPK_BAD    = 2'd3
    } op_kind_t;

    localparam logic [4:0] CODE_READ   = 5'h06;
    localparam logic [4:0] CODE_WRITE  = 5'h05;
    localparam logic [4:0] CODE_FORMAT = 5'h0D;
    localparam logic [7:0] BAD_REPLY   = 8'h80;

    function automatic op_kind_t decode_op(input logic [4:0] code);
        op_kind_t k;
        unique case (code)
            CODE_READ:   k = OPK_READ;
            CODE_WRITE:  k = OPK_WRITE;
            CODE_FORMAT: k = OPK_FORMAT;
            default:     k = OPK_BAD;
        endcase
        return k;
    endfunction

    function automatic logic [3:0] param_len(input op_kind_t k);
        logic [3:0] n;
        unique case (k)
            OPK_READ, OPK_WRITE: n = 4'd8;
            OPK_FORMAT:          n = 4'd5;
            default:             n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fdc_dor.sv
module fdc_dor #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dor_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dor_q <= '0;
        else if (wr_en)
            dor_q <= wdata;
    end

    assert_dor_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dor_q == $past(wdata));
endmodule

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wdata,
    output logic [DEPTH*DW-1:0] bytes_flat
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && wr_idx == IW'(g))
                slot_q <= wdata;
        end
        assign bytes_flat[g*DW +: DW] = slot_q;
    end

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IW'(DEPTH));
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 7,
    parameter logic [DW-1:0] BAD_CODE = 8'h80,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                load_bad,
    input  logic [DEPTH*DW-1:0] load_data,
    input  logic                rd_active,
    input  logic [IW-1:0]       sel,
    output logic [DW-1:0]       rd_byte
);
    logic [DW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (load_en)
                slot[g] <= load_data[g*DW +: DW];
            else if (load_bad)
                slot[g] <= (g == 0) ? BAD_CODE : '0;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sel == IW'(i))
                rd_byte = slot[i];
    end

    assert_sel_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> sel < IW'(DEPTH));
endmodule

// File: rtl/fdc_seq_fsm.sv
module fdc_seq_fsm
    import fdc_seq_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int RES_BYTES  = 7,
    localparam int PIW       = $clog2(MAX_PARAMS + 1),
    localparam int RIW       = $clog2(RES_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           cmd_wr,
    input  logic [7:0]     cmd_byte,
    input  logic           res_rd,
    input  logic           exec_done,
    output seq_state_t     st_q,
    output logic [PIW-1:0] p_idx,
    output logic [RIW-1:0] r_idx,
    output logic           param_we,
    output logic           res_load,
    output logic           bad_load,
    output logic           exec_start,
    output op_kind_t       op_q,
    output logic [2:0]     flags_q,
    output logic           irq
);
    seq_state_t     st_d;
    logic [RIW-1:0] r_cnt;
    logic [PIW-1:0] need;
    op_kind_t       op_in;

    assign op_in    = decode_op(cmd_byte[4:0]);
    assign need     = PIW'(param_len(op_q));
    assign param_we = run && st_q == ST_PARAM && cmd_wr;
    assign res_load = run && st_q == ST_EXEC && exec_done;
    assign bad_load = run && st_q == ST_IDLE && cmd_wr && op_in == OPK_BAD;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (cmd_wr) st_d = (op_in == OPK_BAD) ? ST_RESULT : ST_PARAM;
            ST_PARAM:  if (cmd_wr && p_idx == need - 1'b1) st_d = ST_EXEC;
            ST_EXEC:   if (exec_done) st_d = ST_RESULT;
            ST_RESULT: if (res_rd && r_idx == r_cnt - 1'b1) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
        if (!run)
            st_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_idx      <= '0;
            r_idx      <= '0;
            r_cnt      <= '0;
            exec_start <= 1'b0;
            op_q       <= OPK_READ;
            flags_q    <= '0;
            irq        <= 1'b0;
        end else if (!run) begin
            p_idx      <= '0;
            r_idx      <= '0;
            exec_start <= 1'b0;
            irq        <= 1'b0;
        end else begin
            exec_start <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (cmd_wr) begin
                    op_q    <= op_in;
                    flags_q <= cmd_byte[7:5];
                    p_idx   <= '0;
                    r_idx   <= '0;
                    r_cnt   <= RIW'(1);
                end
                ST_PARAM: if (cmd_wr) begin
                    p_idx <= p_idx + 1'b1;
                    if (p_idx == need - 1'b1)
                        exec_start <= 1'b1;
                end
                ST_EXEC: if (exec_done) begin
                    r_idx <= '0;
                    r_cnt <= RIW'(RES_BYTES);
                    irq   <= 1'b1;
                end
                ST_RESULT: if (res_rd) begin
                    irq   <= 1'b0;
                    r_idx <= r_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);
    assert_start_in_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> st_q == ST_EXEC);
    assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q == ST_IDLE && !irq));
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(st_q == ST_EXEC && exec_done));
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && res_rd) |=> !irq);
    assert_bad_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_load |=> (st_q == ST_RESULT && !exec_start && !irq));
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int DW         = 8,
    parameter int MAX_PARAMS = 8,
    parameter int RES_BYTES  = 7,
    parameter logic [2:0] OFS_DOR  = 3'd2,
    parameter logic [2:0] OFS_MSR  = 3'd4,
    parameter logic [2:0] OFS_DATA = 3'd5,
    localparam int PIW = $clog2(MAX_PARAMS + 1),
    localparam int RIW = $clog2(RES_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               host_addr,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [DW-1:0]            host_wdata,
    output logic [DW-1:0]            host_rdata,
    output logic                     irq,
    output logic [1:0]               drive_sel,
    output logic                     dma_gate,
    output logic [3:0]               motor_en,
    output logic                     exec_start,
    output logic [1:0]               exec_op,
    output logic [2:0]               exec_flags,
    output logic [MAX_PARAMS*DW-1:0] exec_params,
    output logic [DW+1:0]            fmt_id_bytes,
    input  logic                     exec_done,
    input  logic [RES_BYTES*DW-1:0]  exec_result
);
    logic [DW-1:0]  dor_q;
    logic           dor_wr, data_wr, data_rd, run_eff;
    seq_state_t     st_q;
    logic [PIW-1:0] p_idx;
    logic [RIW-1:0] r_idx;
    logic           param_we, res_load, bad_load;
    op_kind_t       op_q;
    logic [DW-1:0]  res_byte, msr;

    assign dor_wr  = host_wr && host_addr == OFS_DOR;
    assign data_wr = host_wr && host_addr == OFS_DATA;
    assign data_rd = host_rd && host_addr == OFS_DATA && st_q == ST_RESULT;
    assign run_eff = dor_wr ? host_wdata[2] : dor_q[2];

    fdc_dor #(.DW(DW)) u_dor (
        .clk(clk), .rst_n(rst_n), .wr_en(dor_wr), .wdata(host_wdata), .dor_q(dor_q)
    );

    fdc_seq_fsm #(.MAX_PARAMS(MAX_PARAMS), .RES_BYTES(RES_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run_eff), .cmd_wr(data_wr),
        .cmd_byte(host_wdata[7:0]), .res_rd(data_rd), .exec_done(exec_done),
        .st_q(st_q), .p_idx(p_idx), .r_idx(r_idx), .param_we(param_we),
        .res_load(res_load), .bad_load(bad_load), .exec_start(exec_start),
        .op_q(op_q), .flags_q(exec_flags), .irq(irq)
    );

    fdc_param_store #(.DW(DW), .DEPTH(MAX_PARAMS)) u_params (
        .clk(clk), .rst_n(rst_n), .wr_en(param_we), .wr_idx(p_idx),
        .wdata(host_wdata), .bytes_flat(exec_params)
    );

    fdc_result_buf #(.DW(DW), .DEPTH(RES_BYTES), .BAD_CODE(BAD_REPLY)) u_res (
        .clk(clk), .rst_n(rst_n), .load_en(res_load), .load_bad(bad_load),
        .load_data(exec_result), .rd_active(data_rd), .sel(r_idx), .rd_byte(res_byte)
    );

    assign drive_sel    = dor_q[1:0];
    assign dma_gate     = dor_q[3];
    assign motor_en     = dor_q[7:4];
    assign exec_op      = op_q;
    assign fmt_id_bytes = {exec_params[2*DW +: DW], 2'b00};

    always_comb begin
        msr = '0;
        if (dor_q[2]) begin
            msr[7] = st_q != ST_EXEC;
            msr[6] = st_q == ST_RESULT;
            msr[4] = st_q != ST_IDLE;
        end
    end

    always_comb begin
        case (host_addr)
            OFS_DOR:  host_rdata = dor_q;
            OFS_MSR:  host_rdata = msr;
            OFS_DATA: host_rdata = (st_q == ST_RESULT) ? res_byte : '0;
            default:  host_rdata = '0;
        endcase
    end

    assert_msr_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_start && !dor_wr) |=> (st_q != ST_PARAM));
    assert_collision_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dor_wr && !host_wdata[2]) |=> !irq);
endmodule

// File: tb/sim_fdc_cmd_seq.sv
`timescale 1ns/1ps
module sim_fdc_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq, dma_gate, exec_start, exec_done = 1'b0;
    logic [1:0]  drive_sel, exec_op;
    logic [3:0]  motor_en;
    logic [2:0]  exec_flags;
    logic [63:0] exec_params;
    logic [9:0]  fmt_id_bytes;
    logic [55:0] exec_result = '0;

    int n_chk = 0, n_err = 0;

    fdc_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .drive_sel(drive_sel), .dma_gate(dma_gate), .motor_en(motor_en),
        .exec_start(exec_start), .exec_op(exec_op), .exec_flags(exec_flags),
        .exec_params(exec_params), .fmt_id_bytes(fmt_id_bytes),
        .exec_done(exec_done), .exec_result(exec_result)
    );

    always #2 clk = ~clk;

    function automatic int exp_kind(input logic [7:0] c);
        case (c[4:0])
            5'h06:   return 0;
            5'h05:   return 1;
            5'h0D:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_len(input int k);
        return (k == 2) ? 5 : (k == 3) ? 0 : 8;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_done(input logic [55:0] r);
        @(negedge clk);
        exec_done = 1'b1; exec_result = r;
        @(negedge clk);
        exec_done = 1'b0;
    endtask

    // full command: opcode, params, checks on start and phases
    task automatic run_cmd(input logic [7:0] c, input logic [55:0] res);
        logic [7:0] p [8];
        logic [7:0] v;
        logic [63:0] exp_p;
        int k, n;
        k = exp_kind(c);
        n = exp_len(k);
        exp_p = exec_params;
        wr(3'd5, c);
        if (k == 3) begin
            chk("R10 no start", {63'd0, exec_start}, 64'd0);
            rd(3'd4, v); chk("R10 msr result", {56'd0, v}, 64'hD0);
            rd(3'd5, v); chk("R10 reply byte", {56'd0, v}, 64'h80);
            chk("R10 irq low", {63'd0, irq}, 64'd0);
            rd(3'd4, v); chk("R10 back idle", {56'd0, v}, 64'h80);
            return;
        end
        chk("R5 flags", {61'd0, exec_flags}, {61'd0, c[7:5]});
        rd(3'd4, v); chk("R4 msr param", {56'd0, v}, 64'h90);
        for (int i = 0; i < n; i++) begin
            p[i] = 8'($urandom);
            exp_p[i*8 +: 8] = p[i];
            if (i < n - 1) chk("R6 no early start", {63'd0, exec_start}, 64'd0);
            wr(3'd5, p[i]);
        end
        chk(k == 2 ? "R7 start" : "R6 start", {63'd0, exec_start}, 64'd1);
        chk("R6 op", {62'd0, exec_op}, 64'(k));
        chk("R6 params", exec_params, exp_p);
        if (k == 2) chk("R7 id bytes", {54'd0, fmt_id_bytes}, 64'(4 * int'(p[2])));
        @(negedge clk);
        chk("R6 start one cycle", {63'd0, exec_start}, 64'd0);
        rd(3'd4, v); chk("R4 msr exec", {56'd0, v}, 64'h10);
        wr(3'd5, 8'h5A);
        chk("R11 write in exec ignored", exec_params, exp_p);
        rd(3'd4, v); chk("R11 still exec", {56'd0, v}, 64'h10);
        pulse_done(res);
        chk("R8 irq set", {63'd0, irq}, 64'd1);
        rd(3'd4, v); chk("R4 msr result", {56'd0, v}, 64'hD0);
        for (int i = 0; i < 7; i++) begin
            rd(3'd5, v);
            chk("R8 result byte", {56'd0, v}, {56'd0, res[i*8 +: 8]});
            if (i == 0) chk("R9 irq cleared", {63'd0, irq}, 64'd0);
            if (i == 2) begin
                wr(3'd5, 8'hC6);
                rd(3'd4, v); chk("R11 write in result ignored", {56'd0, v}, 64'hD0);
            end
        end
        rd(3'd4, v); chk("R8 idle after seven", {56'd0, v}, 64'h80);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] c;
        logic [55:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 start", {63'd0, exec_start}, 64'd0);
        rst_n = 1'b1;
        rd(3'd2, v); chk("R1 dor", {56'd0, v}, 64'd0);
        rd(3'd4, v); chk("R1 msr", {56'd0, v}, 64'd0);

        // R3 data writes while held
        wr(3'd5, 8'hC6);
        rd(3'd4, v); chk("R3 msr held", {56'd0, v}, 64'd0);

        // R2 random DOR values with run low, then 0x1C
        for (int i = 0; i < 4; i++) begin
            c = 8'($urandom) & 8'hFB;
            wr(3'd2, c);
            rd(3'd2, v); chk("R2 dor readback", {56'd0, v}, {56'd0, c});
            chk("R2 motors", {60'd0, motor_en}, {60'd0, c[7:4]});
            chk("R2 drive", {62'd0, drive_sel}, {62'd0, c[1:0]});
        end
        wr(3'd2, 8'h1C);
        chk("R2 motor0", {60'd0, motor_en}, 64'd1);
        chk("R2 dma gate", {63'd0, dma_gate}, 64'd1);
        chk("R2 drive0", {62'd0, drive_sel}, 64'd0);
        rd(3'd4, v); chk("R4 msr idle", {56'd0, v}, 64'h80);

        // R11 stray done and data read in idle
        pulse_done(56'hFFFF_FFFF_FFFF_FF);
        chk("R11 stray done irq", {63'd0, irq}, 64'd0);
        rd(3'd4, v); chk("R11 stray done msr", {56'd0, v}, 64'h80);
        rd(3'd5, v); chk("R11 idle data read", {56'd0, v}, 64'd0);

        // directed commands
        run_cmd(8'hC6, 56'h07_06_05_04_03_02_01);
        run_cmd(8'hC5, 56'hA0_B1_C2_D3_E4_F5_06);
        run_cmd(8'h4D, 56'h11_22_33_44_55_66_77);
        run_cmd(8'h1F, '0);

        // R3 abort mid-command
        wr(3'd5, 8'hC6); wr(3'd5, 8'h00); wr(3'd5, 8'h01);
        wr(3'd2, 8'h18);
        rd(3'd4, v); chk("R3 msr after clear", {56'd0, v}, 64'd0);
        wr(3'd2, 8'h1C);
        rd(3'd4, v); chk("R3 msr after restore", {56'd0, v}, 64'h80);

        // random commands
        for (int i = 0; i < 30; i++) begin
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: c = {3'($urandom), 5'h06};
                1: c = {3'($urandom), 5'h05};
                2: c = {3'($urandom), 5'h0D};
                default: begin
                    c = 8'($urandom);
                    while (exp_kind(c) != 3) c = 8'($urandom);
                end
            endcase
            r = {24'($urandom), 32'($urandom)};
            run_cmd(c, r);
        end

        // R12 collision: exec_done and run clear on the same edge
        wr(3'd5, 8'h4D);
        for (int i = 0; i < 5; i++) wr(3'd5, 8'(i + 3));
        @(negedge clk);
        exec_done = 1'b1; exec_result = 56'h1234;
        host_addr = 3'd2; host_wdata = 8'h18; host_wr = 1'b1;
        @(negedge clk);
        exec_done = 1'b0; host_wr = 1'b0;
        chk("R12 irq stays low", {63'd0, irq}, 64'd0);
        rd(3'd4, v); chk("R12 msr held", {56'd0, v}, 64'd0);
        wr(3'd2, 8'h1C);
        rd(3'd4, v); chk("R12 idle after restore", {56'd0, v}, 64'h80);
        rd(3'd5, v); chk("R12 no result pending", {56'd0, v}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule